// File: doc/BRIEF.md
# Sync-Hunting Byte-Stream Frame Deframer

This block sits behind a bit-serial demodulator that hands over received bits packed into bytes, with the first bit on air in bit 0 of each byte. The byte boundaries the demodulator picks bear no relation to the frame. The block hunts for the 16-bit sync word 0xB24D at any bit position in that stream. Once it has locked, it realigns every later byte to the bit offset where the sync ended. Each rebuilt byte goes into a frame buffer that a consumer reads through a synchronous read port.

After sync, the first rebuilt byte is a length value L that counts itself. The frame then carries L-1 payload bytes and a two-byte check value. The block runs a CRC-16 over everything from the length byte through the check bytes, and flags the frame good when the remainder is zero. Once the frame is complete, the block holds its results until the consumer pulses the frame-reset input. A length of zero, or one too large for the buffer, is rejected and the hunt starts again.

Top module: `nfc_deframer`

## Requirements
- R1: After `rst` or a `frame_clr` pulse, `frame_done` and `crc_ok` are 0, `frame_len` is 0 and the block hunts for sync. `frame_clr` takes priority over a byte offered in the same cycle.
- R2: While hunting, a zero byte is discarded. The first nonzero byte is loaded as the start of a sync attempt, so any number of zero bytes may precede a frame.
- R3: A zero byte during a sync attempt abandons the attempt. A frame whose sync begins in the next nonzero byte is still received correctly.
- R4: Bit 0 of each input byte is the earliest bit on air, and every stored byte holds its earliest air bit in bit 7. The sync word 0xB24D (earliest bit = bit 15) is found when it starts at any of the eight bit offsets within a byte. Every later stored byte is built from the bits that follow the sync, across input byte boundaries.
- R5: When the sync ends exactly on an input byte boundary, the next input byte, bit-reversed, is the length byte.
- R6: The read port returns the byte at `rd_addr` one clock after the address is presented. Address 0 reads 0xB2 and address 1 reads 0x4D.
- R7: The length byte L is stored at address 2, the payload at addresses 3..L+1 and the two check bytes at L+2 and L+3. Once L is taken, `frame_len` reads L+4, including at L = 255.
- R8: `frame_done` is 0 until the byte that completes stored address L+3 is taken, and is 1 from the clock edge that takes it.
- R9: `crc_ok` is 1 with `frame_done` exactly when the CRC-16 over addresses 2..L+3 is zero. The CRC uses polynomial 0x1021, initial value 0 and MSB-first bit order, with the check value sent high byte first.
- R10: After `frame_done`, further input bytes change neither `frame_len`, `frame_done`, `crc_ok` nor the stored bytes until `frame_clr`.
- R11: A length byte of 0, or one with L+4 above the buffer depth, returns the block to the hunt with `frame_len` 0 and no `frame_done`. A following frame is received without a `frame_clr`.
- R12: `frame_clr` during a partly received frame abandons it, and the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a received byte this cycle |
| in_byte | input | 8 | Received byte, earliest air bit in bit 0 |
| frame_clr | input | 1 | Synchronous frame reset, back to the sync hunt |
| rd_addr | input | 9 | Frame buffer read address |
| rd_data | output | 8 | Frame buffer byte, one cycle after `rd_addr` |
| frame_len | output | 9 | Stored frame size L+4, 0 while no length is held |
| frame_done | output | 1 | Frame fully received |
| crc_ok | output | 1 | Completed frame has a zero CRC remainder |

## Verification
The hardest state to reach from the ports is a lock at a nonzero bit offset. There the sync straddles three input bytes, and every stored byte mixes the tail of one input byte with the head of the next. The stimulus builds each frame as a serial bit string: a random count of whole zero bytes, then 0 to 7 zero bits, then the sync, the frame and zero padding, all repacked into bytes. This drives every offset, both with and without leading zero bytes, and the bench compares the realigned buffer byte by byte. A zero byte inside a sync attempt, a zero length byte and a clear in mid-frame are built the same way as directed streams.

// File: rtl/nfd_pkg.sv
package nfd_pkg;

  localparam logic [15:0] SYNC_WORD = 16'hB24D;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam int          LEN_W     = 9;   // holds 255 + 4

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRY,
    ST_LEN,
    ST_BODY,
    ST_FULL
  } dfr_state_e;

  function automatic logic [7:0] bit_rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // one byte, MSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] n;
    logic        fb;
    n = c;
    for (int i = 7; i >= 0; i--) begin
      fb = n[15] ^ d[i];
      n  = {n[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return n;
  endfunction

endpackage

// File: rtl/nfd_sync_scan.sv
// Tests the sync window after each of the eight bits of a byte.
module nfd_sync_scan
  import nfd_pkg::*;
(
  input  logic [15:0] sreg,
  input  logic [7:0]  air,        // earliest air bit in bit 7
  output logic        hit,
  output logic [2:0]  offset,     // bits consumed at match, 8 reads as 0
  output logic [15:0] sreg_next
);

  logic [23:0] cat;
  logic [8:1]  match;

  assign cat       = {sreg, air};
  assign sreg_next = {sreg[7:0], air};

  genvar k;
  generate
    for (k = 1; k <= 8; k++) begin : g_win
      assign match[k] = (cat[23-k -: 16] == SYNC_WORD);
    end
  endgenerate

  // earliest bit position wins
  always_comb begin
    hit    = 1'b0;
    offset = 3'd0;
    for (int i = 8; i >= 1; i--) begin
      if (match[i]) begin
        hit    = 1'b1;
        offset = 3'(i);
      end
    end
  end

endmodule

// File: rtl/nfd_realign.sv
// Rebuilds frame bytes from the tail of the last input byte and the head of this one.
module nfd_realign (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] air_cur,
  input  logic [2:0] offset,
  output logic [7:0] aligned
);

  logic [7:0]  prev_air;
  logic [15:0] shifted;

  always_ff @(posedge clk) begin
    if (rst)           prev_air <= 8'h00;
    else if (in_valid) prev_air <= air_cur;
  end

  always_comb begin
    shifted = {prev_air, air_cur} >> (4'd8 - {1'b0, offset});
    aligned = (offset == 3'd0) ? air_cur : shifted[7:0];
  end

endmodule

// File: rtl/nfd_frame_ram.sv
module nfd_frame_ram #(
  parameter int DEPTH = 260,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R7
  always_comb begin
    if (we) begin
      waddr_range_chk: assert (32'(waddr) < DEPTH);
    end
  end

endmodule

// File: rtl/nfc_deframer.sv
module nfc_deframer
  import nfd_pkg::*;
#(
  parameter int DEPTH = 260,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             frame_clr,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic [LEN_W-1:0] frame_len,
  output logic             frame_done,
  output logic             crc_ok
);

  localparam int CW = (AW > LEN_W) ? AW : LEN_W;

  dfr_state_e    state;
  logic [7:0]    air_in, aligned, wdata, ram_q, hdr_q;
  logic [15:0]   sreg, sreg_next, crc, crc_n;
  logic          scan_hit, take, len_bad, we, hdr_hit;
  logic [2:0]    scan_off, offset_q;
  logic [AW-1:0] pos, last_pos, waddr;
  logic [CW-1:0] len_ext;

  assign air_in  = bit_rev8(in_byte);
  assign take    = in_valid && !frame_clr;
  assign len_ext = CW'(aligned);
  assign len_bad = (aligned == 8'h00) || (len_ext + CW'(4) > CW'(DEPTH));
  assign crc_n   = crc16_byte((state == ST_LEN) ? 16'h0000 : crc, aligned);

  nfd_sync_scan u_scan (
    .sreg      (sreg),
    .air       (air_in),
    .hit       (scan_hit),
    .offset    (scan_off),
    .sreg_next (sreg_next)
  );

  nfd_realign u_align (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .air_cur  (air_in),
    .offset   (offset_q),
    .aligned  (aligned)
  );

  always_ff @(posedge clk) begin
    if (rst || frame_clr) begin
      state      <= ST_IDLE;
      sreg       <= 16'h0000;
      offset_q   <= 3'd0;
      pos        <= '0;
      last_pos   <= '0;
      crc        <= 16'h0000;
      frame_len  <= '0;
      frame_done <= 1'b0;
      crc_ok     <= 1'b0;
    end else if (in_valid) begin
      unique case (state)
        ST_IDLE: begin
          if (in_byte != 8'h00) begin
            sreg  <= {8'h00, air_in};
            state <= ST_TRY;
          end
        end
        ST_TRY: begin
          if (in_byte == 8'h00) begin
            sreg  <= 16'h0000;
            state <= ST_IDLE;
          end else if (scan_hit) begin
            offset_q <= scan_off;
            state    <= ST_LEN;
          end else begin
            sreg <= sreg_next;
          end
        end
        ST_LEN: begin
          if (len_bad) begin
            sreg     <= 16'h0000;
            offset_q <= 3'd0;
            state    <= ST_IDLE;
          end else begin
            frame_len <= LEN_W'({1'b0, aligned} + 9'd4);
            last_pos  <= AW'(len_ext + CW'(3));
            pos       <= AW'(3);
            crc       <= crc_n;
            state     <= ST_BODY;
          end
        end
        ST_BODY: begin
          crc <= crc_n;
          pos <= pos + AW'(1);
          if (pos == last_pos) begin
            state      <= ST_FULL;
            frame_done <= 1'b1;
            crc_ok     <= (crc_n == 16'h0000);
          end
        end
        default: ;
      endcase
    end
  end

  assign we    = take && (((state == ST_LEN) && !len_bad) || (state == ST_BODY));
  assign waddr = (state == ST_LEN) ? AW'(2) : pos;
  assign wdata = aligned;

  nfd_frame_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (rd_addr),
    .rdata (ram_q)
  );

  // sync bytes are constants, not stored
  always_ff @(posedge clk) begin
    hdr_hit <= (rd_addr < AW'(2));
    hdr_q   <= rd_addr[0] ? SYNC_WORD[7:0] : SYNC_WORD[15:8];
  end

  assign rd_data = hdr_hit ? hdr_q : ram_q;

  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (rst)
    frame_clr |=> (frame_len == '0) && !frame_done && !crc_ok);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && in_valid && in_byte == 8'h00 && !frame_clr) |=> state == ST_IDLE);

  // R7
  done_len_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> frame_len >= LEN_W'(5));

  // R9
  ok_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    crc_ok |-> frame_done);

  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !frame_clr) |=> frame_done && $stable(frame_len) && $stable(crc_ok));

endmodule

// File: tb/tb_nfc_deframer.sv
module tb_nfc_deframer;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 260;
  localparam int AW         = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [7:0]    in_byte;
  logic          frame_clr;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic [8:0]    frame_len;
  logic          frame_done;
  logic          crc_ok;

  int checks = 0;
  int errors = 0;

  logic       abit  [0:8191];
  int         nbits;
  logic [7:0] exp_b [0:DEPTH-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  nfc_deframer #(.DEPTH(DEPTH)) dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .frame_clr  (frame_clr),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .frame_len  (frame_len),
    .frame_done (frame_done),
    .crc_ok     (crc_ok)
  );

  function automatic logic [15:0] ref_crc(input int lo, input int hi);
    logic [15:0] c;
    logic        fb;
    c = 16'h0000;
    for (int i = lo; i <= hi; i++) begin
      for (int j = 7; j >= 0; j--) begin
        fb = c[15] ^ exp_b[i][j];
        c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic push8(input logic [7:0] v);
    for (int j = 7; j >= 0; j--) begin
      abit[nbits] = v[j];
      nbits++;
    end
  endtask

  task automatic push_zero_bits(input int n);
    for (int i = 0; i < n; i++) begin
      abit[nbits] = 1'b0;
      nbits++;
    end
  endtask

  // sync, length, payload and check bytes, air order
  task automatic build_frame(input int len, input bit corrupt);
    logic [15:0] c;
    exp_b[0] = 8'hB2;
    exp_b[1] = 8'h4D;
    exp_b[2] = 8'(len);
    for (int i = 3; i <= len + 1; i++) exp_b[i] = 8'($urandom);
    c = ref_crc(2, len + 1);
    exp_b[len+2] = c[15:8];
    exp_b[len+3] = c[7:0];
    if (corrupt) exp_b[len+3] = exp_b[len+3] ^ (8'h01 << ($urandom % 8));
    for (int i = 0; i <= len + 3; i++) push8(exp_b[i]);
  endtask

  // pads to a byte, packs earliest bit into bit 0, sends up to limit bytes
  task automatic send_bits(input bit check_last, input int limit, input string tag);
    int         nb;
    logic [7:0] b;
    while (nbits % 8 != 0) begin
      abit[nbits] = 1'b0;
      nbits++;
    end
    nb = nbits / 8;
    if (limit >= 0 && limit < nb) nb = limit;
    for (int i = 0; i < nb; i++) begin
      for (int j = 0; j < 8; j++) b[j] = abit[8*i + j];
      if ($urandom % 4 == 0) @(negedge clk);
      if (check_last && i == nb - 1)
        chk(frame_done == 1'b0, {tag, " R8 done early"}, int'(frame_done), 0);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'($urandom);
    end
  endtask

  task automatic read_chk(input int addr, input logic [7:0] expv, input string tag);
    rd_addr = AW'(addr);
    @(negedge clk);
    chk(rd_data === expv, tag, int'(rd_data), int'(expv));
  endtask

  task automatic check_frame(input int len, input bit corrupt, input string tag);
    chk(frame_done == 1'b1, {tag, " R8 done"}, int'(frame_done), 1);
    chk(frame_len == 9'(len + 4), {tag, " R7 len"}, int'(frame_len), len + 4);
    chk(crc_ok == !corrupt, {tag, " R9 crc"}, int'(crc_ok), int'(!corrupt));
    for (int a = 0; a <= len + 3; a++)
      read_chk(a, exp_b[a], (a < 2) ? {tag, " R6 hdr"} : {tag, " R4 data"});
  endtask

  task automatic do_clear;
    frame_clr = 1'b1;
    in_valid  = 1'b1;     // R1: clear wins over a byte
    in_byte   = 8'hFF;
    @(negedge clk);
    frame_clr = 1'b0;
    in_valid  = 1'b0;
  endtask

  task automatic run_frame(input int p, input int z, input int len, input bit corrupt,
                           input string tag);
    do_clear;
    nbits = 0;
    push_zero_bits(8*p + z);
    build_frame(len, corrupt);
    send_bits(1'b1, -1, tag);
    check_frame(len, corrupt, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    checks++;
    errors++;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00; frame_clr = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(frame_len == 0, "R1 reset len", int'(frame_len), 0);
    chk(frame_done == 0, "R1 reset done", int'(frame_done), 0);
    chk(crc_ok == 0, "R1 reset crc_ok", int'(crc_ok), 0);

    // R5 offset 0, minimum length
    run_frame(0, 0, 1, 1'b0, "R5");
    // R4 odd offsets
    run_frame(0, 3, 6, 1'b0, "R4");
    run_frame(1, 7, 17, 1'b0, "R4");
    // R9 damaged check value
    run_frame(0, 5, 9, 1'b1, "R9");
    // R2 leading zero bytes
    run_frame(3, 1, 4, 1'b0, "R2");
    // R7 largest length
    run_frame(0, 5, 255, 1'b0, "R7");

    // R10 extra bytes after completion
    nbits = 0;
    for (int i = 0; i < 6; i++) push8(8'($urandom) | 8'h01);
    send_bits(1'b0, -1, "R10");
    check_frame(255, 1'b0, "R10");

    // R1 clear after completion
    do_clear;
    chk(frame_len == 0, "R1 clear len", int'(frame_len), 0);
    chk(frame_done == 0, "R1 clear done", int'(frame_done), 0);
    chk(crc_ok == 0, "R1 clear crc_ok", int'(crc_ok), 0);

    // R3 zero byte inside a sync attempt, then a real frame
    nbits = 0;
    push8(8'hB2);
    push8(8'h00);
    build_frame(7, 1'b0);
    send_bits(1'b1, -1, "R3");
    check_frame(7, 1'b0, "R3");

    // R11 zero length byte, then a frame with no clear
    do_clear;
    nbits = 0;
    push8(8'h00); push8(8'hB2); push8(8'h4D); push8(8'h00);
    send_bits(1'b0, -1, "R11");
    chk(frame_len == 0, "R11 len", int'(frame_len), 0);
    chk(frame_done == 0, "R11 done", int'(frame_done), 0);
    nbits = 0;
    push8(8'h00);
    build_frame(5, 1'b0);
    send_bits(1'b1, -1, "R11");
    check_frame(5, 1'b0, "R11");

    // R12 clear in mid-frame
    do_clear;
    nbits = 0;
    push_zero_bits(2);
    build_frame(12, 1'b0);
    send_bits(1'b0, 8, "R12");
    do_clear;
    chk(frame_len == 0, "R12 len", int'(frame_len), 0);
    chk(frame_done == 0, "R12 done", int'(frame_done), 0);
    run_frame(1, 4, 9, 1'b0, "R12");

    // random frames: R4 offsets, R9 check values
    for (int n = 0; n < 24; n++) begin
      run_frame($urandom % 3, $urandom % 8, 1 + ($urandom % 48), ($urandom % 4) == 0, "R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule